// File: doc/BRIEF.md
# Per-Bank Auto-Precharge Timing Tracker

This block keeps, for every bank of a multi-bank DDR SDRAM controller, the bank's state (idle, active or precharging) and the cycle counters that govern it. It watches the command stream that the controller issues, one command per cycle tagged with a bank number. It reports three legality flags per bank: row open, column access and precharge. The scheduler consults these flags before issuing anything. Refresh, mode programming, the data path and address mapping are handled elsewhere. All timing values are whole clock cycles and are set by parameters.

Auto-precharge gets special care. A read with auto-precharge may be issued as soon as the row-to-column delay has passed, even while the minimum row-active time is still running. Its internal precharge starts half a burst later. With a write the start comes half a burst plus four cycles after the command. In both cases the start is pushed back if the minimum row-active time has not yet been met. The block marks that start with a one-cycle pulse and marks the return to idle with another pulse. While an auto-precharge is in flight, column commands to the other banks are held off for a short window. Row commands to other banks are never held off.

A command that breaks a rule is ignored and sets a sticky violation flag, which also captures the bank of the first offending command.

Top module: `bank_ap_tracker`

## Requirements
- R1: After reset every bank is idle: canAct and canPre are high for all banks, canCol, apStart and idleRet are low, and violation is low.
- R2: After an ACT to a bank in cycle k, column commands to that bank are legal from cycle k+T_RCD and not before.
- R3: A manual PRE to an active bank is legal only from cycle k+T_RAS after its ACT in cycle k; a PRE to an idle bank is legal and changes nothing.
- R4: A READA is legal once T_RCD has passed, even before T_RAS. Its internal precharge start, shown as a one-cycle apStart pulse, falls in cycle max(c+BURST_LEN/2, a+T_RAS), where c is the READA cycle and a is the ACT cycle.
- R5: After a WRITA in cycle c, the apStart pulse falls in cycle max(c+BURST_LEN/2+4, a+T_RAS).
- R6: After a READA in cycle c, column commands to every other bank are illegal until cycle c+CAS_LAT+BURST_LEN/2, the cycle after the last data beat, and legal from then on.
- R7: After a WRITA, column commands to every other bank are illegal up to and including the apStart cycle s, and legal again from s+1.
- R8: Auto-precharge activity on one bank never changes canAct or canPre of any other bank.
- R9: Once precharge has started in cycle s, either by apStart or by a manual PRE in cycle s, a new ACT to that bank is legal from cycle s+T_RP. idleRet pulses in exactly that cycle.
- R10: From a READA or WRITA until its apStart, the bank accepts no ACT, no PRE and no column command.
- R11: A command that is illegal in its cycle is ignored. It sets violation in the next cycle, and violation stays high until reset. violBank holds the bank of the first illegal command.
- R12: Commands are encoded on cmd as NOP=0, ACT=1, READ=2, READA=3, WRITE=4, WRITA=5, PRE=6. Code 7 is illegal on any bank and is handled as in R11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cmd | input | 3 | Command issued this cycle (encoding in R12) |
| cmdBank | input | $clog2(NUM_BANKS) | Bank the command addresses |
| canAct | output | NUM_BANKS | ACT to this bank is legal now |
| canCol | output | NUM_BANKS | READ, READA, WRITE or WRITA to this bank is legal now |
| canPre | output | NUM_BANKS | PRE to this bank is legal now |
| apStart | output | NUM_BANKS | Internal precharge of this bank starts this cycle |
| idleRet | output | NUM_BANKS | This bank becomes ready for ACT this cycle |
| violation | output | 1 | Sticky flag: an illegal command was seen |
| violBank | output | $clog2(NUM_BANKS) | Bank of the first illegal command |

## Verification
The legality flags, apStart and idleRet are combinational functions of registered bank state. A command taken at one rising edge is therefore reflected in these outputs during the very next cycle. An offset of N cycles in a requirement means these outputs are due N edges after the command's edge. violation and violBank are registered too, so they change in the cycle right after the offending command. The bench drives and samples on the falling edge and keeps its own cycle index. Every expected value is derived from that index and from the recorded cycles of ACT, READA, WRITA and precharge start. It is never derived from counters in the design.

// File: rtl/ap_track_pkg.sv
package ap_track_pkg;

  typedef enum logic [2:0] {
    CMD_NOP   = 3'd0,
    CMD_ACT   = 3'd1,
    CMD_READ  = 3'd2,
    CMD_READA = 3'd3,
    CMD_WRITE = 3'd4,
    CMD_WRITA = 3'd5,
    CMD_PRE   = 3'd6
  } cmd_e;

  typedef enum logic [1:0] {
    BK_IDLE   = 2'd0,
    BK_ACTIVE = 2'd1,
    BK_PRECH  = 2'd2
  } bankState_e;

  // control -> datapath strobes, one set per bank
  typedef struct packed {
    logic actLoad;
    logic rdApLoad;
    logic wrApLoad;
    logic preLoad;
  } bankStrobe_t;

  // datapath -> control timing status, one set per bank
  typedef struct packed {
    logic rcdMet;
    logic rasMet;
    logic apDue;
    logic rpDone;
    logic rdBlock;
  } bankTime_t;

endpackage

// File: rtl/ap_bank_timer.sv
module ap_bank_timer
  import ap_track_pkg::*;
#(
  parameter int T_RCD     = 3,
  parameter int T_RP      = 3,
  parameter int T_RAS     = 6,
  parameter int BURST_LEN = 4,
  parameter int CAS_LAT   = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  bankStrobe_t stb,
  output bankTime_t   tim
);

  localparam int AGE_MAX    = (T_RAS > T_RCD) ? T_RAS : T_RCD;
  localparam int AGE_W      = $clog2(AGE_MAX + 1);
  localparam int RD_AP_DLY  = BURST_LEN / 2;
  localparam int WR_AP_DLY  = BURST_LEN / 2 + 4;
  localparam int RD_BLK_LEN = CAS_LAT + BURST_LEN / 2;
  localparam int CNT_A      = (WR_AP_DLY > RD_BLK_LEN) ? WR_AP_DLY : RD_BLK_LEN;
  localparam int CNT_MAX    = (CNT_A > T_RP) ? CNT_A : T_RP;
  localparam int CNT_W      = $clog2(CNT_MAX + 1);

  logic [AGE_W-1:0] actAge;   // cycles since ACT, saturating
  logic [CNT_W-1:0] apCnt;    // countdown to the auto-precharge point
  logic [CNT_W-1:0] prCnt;    // countdown of the precharge period
  logic [CNT_W-1:0] blkCnt;   // countdown of the read data window

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      actAge <= '0;
      apCnt  <= '0;
      prCnt  <= '0;
      blkCnt <= '0;
    end else begin
      if (stb.actLoad)
        actAge <= AGE_W'(1);
      else if (actAge != AGE_W'(AGE_MAX))
        actAge <= actAge + 1'b1;

      if (stb.rdApLoad)
        apCnt <= CNT_W'(RD_AP_DLY - 1);
      else if (stb.wrApLoad)
        apCnt <= CNT_W'(WR_AP_DLY - 1);
      else if (apCnt != '0)
        apCnt <= apCnt - 1'b1;

      if (stb.preLoad)
        prCnt <= CNT_W'(T_RP - 1);
      else if (prCnt != '0)
        prCnt <= prCnt - 1'b1;

      if (stb.rdApLoad)
        blkCnt <= CNT_W'(RD_BLK_LEN - 1);
      else if (blkCnt != '0)
        blkCnt <= blkCnt - 1'b1;
    end
  end

  assign tim.rcdMet  = (actAge >= AGE_W'(T_RCD));
  assign tim.rasMet  = (actAge >= AGE_W'(T_RAS));
  assign tim.apDue   = (apCnt == '0);
  assign tim.rpDone  = (prCnt == '0);
  assign tim.rdBlock = (blkCnt != '0);

endmodule

// File: rtl/ap_bank_ctrl.sv
module ap_bank_ctrl
  import ap_track_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BANK_W    = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [2:0]           cmdRaw,
  input  logic [BANK_W-1:0]    cmdBank,
  input  bankTime_t            tim [NUM_BANKS],
  output bankStrobe_t          stb [NUM_BANKS],
  output logic [NUM_BANKS-1:0] canAct,
  output logic [NUM_BANKS-1:0] canCol,
  output logic [NUM_BANKS-1:0] canPre,
  output logic [NUM_BANKS-1:0] apStart,
  output logic [NUM_BANKS-1:0] idleRet,
  output logic                 violation,
  output logic [BANK_W-1:0]    violBank
);

  cmd_e cmd;
  assign cmd = cmd_e'(cmdRaw);

  logic [NUM_BANKS-1:0] blockSrc;
  logic bankOk;
  logic cmdLegal;

  if ((2 ** BANK_W) == NUM_BANKS) begin : gFullRange
    assign bankOk = 1'b1;
  end else begin : gPartRange
    assign bankOk = ({{(32-BANK_W){1'b0}}, cmdBank} < NUM_BANKS);
  end

  always_comb begin
    case (cmd)
      CMD_NOP:   cmdLegal = 1'b1;
      CMD_ACT:   cmdLegal = bankOk && canAct[cmdBank];
      CMD_READ,
      CMD_READA,
      CMD_WRITE,
      CMD_WRITA: cmdLegal = bankOk && canCol[cmdBank];
      CMD_PRE:   cmdLegal = bankOk && canPre[cmdBank];
      default:   cmdLegal = 1'b0;
    endcase
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : gBank
    bankState_e st;
    logic apPend;
    logic wrBlk;
    logic hit;
    logic otherBlk;

    assign hit      = cmdLegal && bankOk && (cmdBank == BANK_W'(b));
    assign otherBlk = |(blockSrc & ~(NUM_BANKS'(1) << b));
    assign blockSrc[b] = tim[b].rdBlock || wrBlk;

    assign apStart[b] = (st == BK_ACTIVE) && apPend && tim[b].apDue && tim[b].rasMet;
    assign idleRet[b] = (st == BK_PRECH) && tim[b].rpDone;
    assign canAct[b]  = (st == BK_IDLE) || idleRet[b];
    assign canPre[b]  = (st == BK_IDLE) || ((st == BK_ACTIVE) && tim[b].rasMet && !apPend);
    assign canCol[b]  = (st == BK_ACTIVE) && tim[b].rcdMet && !apPend && !otherBlk;

    assign stb[b] = '{
      actLoad:  hit && (cmd == CMD_ACT),
      rdApLoad: hit && (cmd == CMD_READA),
      wrApLoad: hit && (cmd == CMD_WRITA),
      preLoad:  apStart[b] || (hit && (cmd == CMD_PRE) && (st == BK_ACTIVE))
    };

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        st     <= BK_IDLE;
        apPend <= 1'b0;
        wrBlk  <= 1'b0;
      end else begin
        case (st)
          BK_IDLE: begin
            if (hit && (cmd == CMD_ACT)) st <= BK_ACTIVE;
          end
          BK_ACTIVE: begin
            if (apStart[b]) begin
              st     <= BK_PRECH;
              apPend <= 1'b0;
              wrBlk  <= 1'b0;
            end else if (hit && (cmd == CMD_PRE)) begin
              st <= BK_PRECH;
            end else if (hit && ((cmd == CMD_READA) || (cmd == CMD_WRITA))) begin
              apPend <= 1'b1;
              wrBlk  <= (cmd == CMD_WRITA);
            end
          end
          BK_PRECH: begin
            if (idleRet[b]) st <= (hit && (cmd == CMD_ACT)) ? BK_ACTIVE : BK_IDLE;
          end
          default: st <= BK_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      violation <= 1'b0;
      violBank  <= '0;
    end else if (!violation && !cmdLegal) begin
      violation <= 1'b1;
      violBank  <= cmdBank;
    end
  end

endmodule

// File: rtl/bank_ap_tracker.sv
module bank_ap_tracker
  import ap_track_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int T_RCD     = 3,
  parameter int T_RP      = 3,
  parameter int T_RAS     = 6,
  parameter int BURST_LEN = 4,
  parameter int CAS_LAT   = 3
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [2:0]                   cmd,
  input  logic [$clog2(NUM_BANKS)-1:0] cmdBank,
  output logic [NUM_BANKS-1:0]         canAct,
  output logic [NUM_BANKS-1:0]         canCol,
  output logic [NUM_BANKS-1:0]         canPre,
  output logic [NUM_BANKS-1:0]         apStart,
  output logic [NUM_BANKS-1:0]         idleRet,
  output logic                         violation,
  output logic [$clog2(NUM_BANKS)-1:0] violBank
);

  localparam int BANK_W = $clog2(NUM_BANKS);

  bankStrobe_t stb [NUM_BANKS];
  bankTime_t   tim [NUM_BANKS];

  ap_bank_ctrl #(
    .NUM_BANKS(NUM_BANKS),
    .BANK_W   (BANK_W)
  ) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .cmdRaw   (cmd),
    .cmdBank  (cmdBank),
    .tim      (tim),
    .stb      (stb),
    .canAct   (canAct),
    .canCol   (canCol),
    .canPre   (canPre),
    .apStart  (apStart),
    .idleRet  (idleRet),
    .violation(violation),
    .violBank (violBank)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : gTimer
    ap_bank_timer #(
      .T_RCD    (T_RCD),
      .T_RP     (T_RP),
      .T_RAS    (T_RAS),
      .BURST_LEN(BURST_LEN),
      .CAS_LAT  (CAS_LAT)
    ) uTimer (
      .clk (clk),
      .rstN(rstN),
      .stb (stb[b]),
      .tim (tim[b])
    );
  end

endmodule

// File: rtl/ap_tracker_chk.sv
module ap_tracker_chk
  import ap_track_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BANK_W    = 2,
  parameter int T_RCD     = 3,
  parameter int T_RP      = 3
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [2:0]           cmd,
  input logic [BANK_W-1:0]    cmdBank,
  input logic [NUM_BANKS-1:0] canAct,
  input logic [NUM_BANKS-1:0] canCol,
  input logic [NUM_BANKS-1:0] canPre,
  input logic [NUM_BANKS-1:0] apStart,
  input logic [NUM_BANKS-1:0] idleRet,
  input logic                 violation,
  input logic [BANK_W-1:0]    violBank
);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : gProp
    AST_ACT_OPENS: assert property (@(posedge clk) disable iff (!rstN) (cmd == CMD_ACT && cmdBank == BANK_W'(b) && canAct[b]) |=> !canAct[b]); // R9
    AST_AP_LOCK: assert property (@(posedge clk) disable iff (!rstN) apStart[b] |-> !(canCol[b] || canPre[b] || canAct[b] || idleRet[b])); // R10
    AST_READA_LOCK: assert property (@(posedge clk) disable iff (!rstN) (cmd == CMD_READA && cmdBank == BANK_W'(b) && canCol[b]) |=> !canCol[b]); // R10
    if (T_RCD > 1) begin : gRcd
      AST_RCD_HOLD: assert property (@(posedge clk) disable iff (!rstN) (cmd == CMD_ACT && cmdBank == BANK_W'(b) && canAct[b]) |=> !canCol[b]); // R2
    end
    if (T_RP > 1) begin : gRp
      AST_RP_HOLD: assert property (@(posedge clk) disable iff (!rstN) apStart[b] |=> !canAct[b]); // R9
    end
  end

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN) violation |=> violation); // R11
  AST_FLAG_BANK: assert property (@(posedge clk) disable iff (!rstN) violation |=> $stable(violBank)); // R11

endmodule

bind bank_ap_tracker ap_tracker_chk #(
  .NUM_BANKS(NUM_BANKS),
  .BANK_W   (BANK_W),
  .T_RCD    (T_RCD),
  .T_RP     (T_RP)
) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .cmd      (cmd),
  .cmdBank  (cmdBank),
  .canAct   (canAct),
  .canCol   (canCol),
  .canPre   (canPre),
  .apStart  (apStart),
  .idleRet  (idleRet),
  .violation(violation),
  .violBank (violBank)
);

// File: tb/sim_bank_ap_tracker.sv
module sim_bank_ap_tracker;

  localparam int CLK_PERIOD = 10;
  localparam int NB  = 4;
  localparam int RCD = 3;
  localparam int RP  = 3;
  localparam int RAS = 6;
  localparam int BL  = 4;
  localparam int CL  = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [2:0] cmd = 3'd0;
  logic [1:0] cmdBank = 2'd0;
  logic [NB-1:0] canAct, canCol, canPre, apStart, idleRet;
  logic violation;
  logic [1:0] violBank;

  always #(CLK_PERIOD / 2) clk = ~clk;

  bank_ap_tracker #(
    .NUM_BANKS(NB), .T_RCD(RCD), .T_RP(RP), .T_RAS(RAS), .BURST_LEN(BL), .CAS_LAT(CL)
  ) u0 (
    .clk(clk), .rstN(rstN), .cmd(cmd), .cmdBank(cmdBank),
    .canAct(canAct), .canCol(canCol), .canPre(canPre),
    .apStart(apStart), .idleRet(idleRet),
    .violation(violation), .violBank(violBank)
  );

  // reference model: 0 idle, 1 active, 2 precharging
  int mSt [NB];
  int mAct [NB];
  int mAp [NB];
  int mPre [NB];
  int mRd [NB];
  bit mApP [NB];
  bit mWb [NB];
  bit eViol;
  int eVB;
  int cyc;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  function automatic bit eAct(int b);
    return (mSt[b] == 0) || (mSt[b] == 2 && cyc >= mPre[b] + RP);
  endfunction

  function automatic bit eIdle(int b);
    return (mSt[b] == 2) && (cyc == mPre[b] + RP);
  endfunction

  function automatic bit eAp(int b);
    return (mSt[b] == 1) && mApP[b] && (cyc == mAp[b]);
  endfunction

  function automatic bit eBlk(int j);
    return (cyc < mRd[j]) || (mWb[j] && cyc <= mAp[j]);
  endfunction

  function automatic bit eCol(int b);
    bit blocked = 1'b0;
    for (int j = 0; j < NB; j++)
      if (j != b && eBlk(j)) blocked = 1'b1;
    return (mSt[b] == 1) && !mApP[b] && (cyc >= mAct[b] + RCD) && !blocked;
  endfunction

  function automatic bit ePre(int b);
    return (mSt[b] == 0) || (mSt[b] == 1 && !mApP[b] && cyc >= mAct[b] + RAS);
  endfunction

  function automatic bit eLegal(int c, int b);
    case (c)
      0: return 1'b1;
      1: return eAct(b);
      2, 3, 4, 5: return eCol(b);
      6: return ePre(b);
      default: return 1'b0;
    endcase
  endfunction

  function automatic int maxOf(int x, int y);
    return (x > y) ? x : y;
  endfunction

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d (cycle %0d)", tag, got, exp, cyc);
    end
  endtask

  task automatic modelReset();
    for (int b = 0; b < NB; b++) begin
      mSt[b] = 0; mAct[b] = 0; mAp[b] = 0; mPre[b] = 0; mRd[b] = 0;
      mApP[b] = 1'b0; mWb[b] = 1'b0;
    end
    eViol = 1'b0;
    eVB = 0;
    cyc = 0;
  endtask

  task automatic doReset();
    rstN = 1'b0;
    cmd = 3'd0;
    cmdBank = 2'd0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    modelReset();
  endtask

  // falling edge: compare all outputs against the model for cycle cyc
  task automatic sync();
    @(negedge clk);
    for (int b = 0; b < NB; b++) begin
      chk("R9 canAct", int'(canAct[b]), int'(eAct(b)));
      chk("R2 canCol", int'(canCol[b]), int'(eCol(b)));
      chk("R3 canPre", int'(canPre[b]), int'(ePre(b)));
      chk("R4 apStart", int'(apStart[b]), int'(eAp(b)));
      chk("R9 idleRet", int'(idleRet[b]), int'(eIdle(b)));
    end
    chk("R11 violation", int'(violation), int'(eViol));
    if (eViol) chk("R11 violBank", int'(violBank), eVB);
  endtask

  // drive the command of cycle cyc and advance the model past the edge
  task automatic issue(input int c, input int b);
    bit legal;
    cmd = 3'(c);
    cmdBank = 2'(b);
    legal = eLegal(c, b);
    if (!legal && !eViol) begin
      eViol = 1'b1;
      eVB = b;
    end
    for (int j = 0; j < NB; j++) begin
      if (eAp(j)) begin
        mSt[j] = 2; mPre[j] = cyc; mApP[j] = 1'b0; mWb[j] = 1'b0;
      end else if (eIdle(j)) begin
        mSt[j] = 0;
      end
    end
    if (legal) begin
      case (c)
        1: begin mSt[b] = 1; mAct[b] = cyc; mApP[b] = 1'b0; end
        3: begin
          mApP[b] = 1'b1;
          mAp[b] = maxOf(cyc + BL / 2, mAct[b] + RAS);
          mRd[b] = cyc + CL + BL / 2;
        end
        5: begin
          mApP[b] = 1'b1;
          mWb[b] = 1'b1;
          mAp[b] = maxOf(cyc + BL / 2 + 4, mAct[b] + RAS);
        end
        6: if (mSt[b] == 1) begin mSt[b] = 2; mPre[b] = cyc; end
        default: ;
      endcase
    end
    cyc++;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));

    // directed timeline
    doReset();
    sync();                                   // cycle 0
    chk("R1 canAct", int'(canAct), 4'hF);
    chk("R1 canCol", int'(canCol), 0);
    chk("R1 canPre", int'(canPre), 4'hF);
    chk("R1 apStart", int'(apStart), 0);
    chk("R1 idleRet", int'(idleRet), 0);
    chk("R1 violation", int'(violation), 0);
    issue(1, 0);
    sync(); issue(1, 1);                      // 1
    sync(); chk("R2 early col", int'(canCol[0]), 0); issue(0, 0);   // 2
    sync();                                   // 3
    chk("R2 col at tRCD", int'(canCol[0]), 1);
    chk("R3 pre before tRAS", int'(canPre[0]), 0);
    chk("R4 READA before tRAS", int'(canCol[0]), 1);
    issue(3, 0);
    sync();                                   // 4
    chk("R6 other col blocked", int'(canCol[1]), 0);
    chk("R10 col locked", int'(canCol[0]), 0);
    chk("R10 pre locked", int'(canPre[0]), 0);
    chk("R10 act locked", int'(canAct[0]), 0);
    issue(0, 0);
    sync(); chk("R4 start held for tRAS", int'(apStart[0]), 0); issue(0, 0);  // 5
    sync(); chk("R4 start at tRAS", int'(apStart[0]), 1); issue(0, 0);        // 6
    sync();                                   // 7
    chk("R6 other col still blocked", int'(canCol[1]), 0);
    chk("R8 other pre free", int'(canPre[1]), 1);
    chk("R8 other act free", int'(canAct[2]), 1);
    chk("R3 pre at tRAS", int'(canPre[1]), 1);
    issue(0, 0);
    sync();                                   // 8
    chk("R6 other col after last beat", int'(canCol[1]), 1);
    chk("R9 act before tRP", int'(canAct[0]), 0);
    issue(5, 1);
    sync();                                   // 9
    chk("R9 act at tRP", int'(canAct[0]), 1);
    chk("R9 idle pulse", int'(idleRet[0]), 1);
    issue(1, 0);
    sync(); issue(0, 0);                      // 10
    sync(); issue(0, 0);                      // 11
    sync(); chk("R7 col blocked by write", int'(canCol[0]), 0); issue(0, 0);  // 12
    sync(); chk("R5 no start yet", int'(apStart[1]), 0); issue(0, 0);         // 13
    sync();                                   // 14
    chk("R5 write start", int'(apStart[1]), 1);
    chk("R7 col blocked at start", int'(canCol[0]), 0);
    chk("R8 act unaffected", int'(canAct[3]), 1);
    issue(0, 0);
    sync();                                   // 15
    chk("R7 col after start", int'(canCol[0]), 1);
    chk("R9 act during tRP", int'(canAct[1]), 0);
    issue(1, 1);                              // early ACT
    sync();                                   // 16
    chk("R11 flag set", int'(violation), 1);
    chk("R11 flag bank", int'(violBank), 1);
    issue(0, 0);
    sync();                                   // 17
    chk("R11 illegal ACT ignored", int'(canAct[1]), 1);
    issue(0, 0);

    // constrained random: legal traffic, rare illegal commands late
    doReset();
    for (int i = 0; i < 3000; i++) begin
      int c;
      int b;
      sync();
      c = int'($urandom_range(0, 6));
      b = int'($urandom_range(0, NB - 1));
      if (!eLegal(c, b) && (cyc < 2500 || $urandom_range(0, 49) != 0)) c = 0;
      issue(c, b);
    end

    // unused code 7
    doReset();
    sync();
    issue(7, 2);
    sync();
    chk("R12 code 7 flagged", int'(violation), 1);
    chk("R12 code 7 bank", int'(violBank), 2);
    chk("R12 state unchanged", int'(canAct), 4'hF);
    issue(0, 0);
    sync();

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule